// File: doc/BRIEF.md
# Spatial Redundancy Generator and Consistency Checker

This unit serves a 32-bit processor that runs bitsliced code with spatially redundant copies of each slice. A word is split into Rs equal fields (Rs = 1, 2 or 4), and field k carries copy k of the slice. Each bit of the slice therefore appears once every 32/Rs bit positions. A copy can be an exact duplicate or an inverted duplicate. Inverted copies keep the Hamming weight of the word constant, and a single fault is unlikely to flip both members of a pair into agreement.

The unit has two operations. A generate operation takes the low 32/Rs bits of the operand and fills the whole word with copies of them. A check operation receives a word that is supposed to be redundant and tests it for consistency:
- For two copies, it returns the per-bit disagreement of the two halves.
- For four copies, it removes the inversion from the inverted copies and returns a bitwise majority vote.

In both cases the unit raises a fault flag whenever the copies do not agree. A 3-bit immediate selects the copy count and the polarity. The unit registers its result once, so it is available one cycle after the operation is presented.

Top module: `redun_unit`

## Requirements
- R1: While reset is asserted and after it is released with no operation, resValid, resData and resFault are all 0.
- R2: An operation presented with opValid high at a rising edge produces resValid high after that edge, with resData and resFault for that operation. In a cycle without opValid, resValid is low and resData and resFault keep their previous values.
- R3: Decoding of opImm:
  - Bit 0 selects inverted (1) or exact (0) redundancy.
  - Bits [2:1] = 01 select two copies, and 10 selects four copies.
  - Bits [2:1] = 00 or 11 select a single copy. In that case both operations return opData unchanged with resFault 0.
- R4: Generating two copies places opData[15:0] in bits [15:0]. It places the same value in bits [31:16], inverted there when bit 0 of opImm is 1.
- R5: Generating four copies places opData[7:0] in each byte. When bit 0 of opImm is 1, bytes 1 and 3 hold the inverted value.
- R6: Checking two inverted copies returns ~(upper half ^ lower half) in bits [15:0] and zero in bits [31:16]. resFault is 1 exactly when that result is nonzero.
- R7: Checking two exact copies returns upper half ^ lower half in bits [15:0] and zero above. resFault is 1 exactly when that result is nonzero.
- R8: Checking four copies works as follows:
  - When bit 0 of opImm is 1, bytes 1 and 3 are inverted back first.
  - Bits [7:0] then receive the per-bit majority of the four bytes. A 2–2 tie takes the value from byte 0.
  - Bits [31:8] are zero.
- R9: A four-copy check raises resFault whenever any normalised byte differs from byte 0, including when the vote recovers the value.
- R10: opCheck = 0 selects generate and opCheck = 1 selects check. A generate operation always returns resFault 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCheck | input | 1 | 1 = check, 0 = generate |
| opImm | input | 3 | Copy count and polarity selector |
| opData | input | 32 | Operand word |
| resValid | output | 1 | Result registered from the previous cycle's operation |
| resData | output | 32 | Generated word, or the check result |
| resFault | output | 1 | Copies disagree (check operations only) |

## Verification
The assertions assume that opValid, opCheck, opImm and opData are known (not X) at every rising edge after reset, including the codes 00 and 11 in opImm[2:1]. They also assume that an idle cycle may carry arbitrary operand values. The stimulus drives every input on falling edges only, and it deliberately toggles the operand and opCheck during idle cycles, so that the hold behaviour is exercised against changing inputs. All eight immediate codes are applied with both operations.

The four-copy check is swept over every 8-bit slice value, in both polarities. Each value is applied clean, with every single-bit flip, and with a 2–2 tie, so that majority recovery and tie resolution both occur.

// File: rtl/redun_pkg.sv
package redun_pkg;

  typedef enum logic [1:0] {
    CP_ONE  = 2'd0,
    CP_TWO  = 2'd1,
    CP_FOUR = 2'd2
  } copyMode_t;

  typedef struct packed {
    logic      load;
    logic      isCheck;
    logic      complMode;
    copyMode_t copies;
  } ctrlStrobe_t;

endpackage

// File: rtl/redun_ctrl.sv
module redun_ctrl
  import redun_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        opCheck,
  input  logic [2:0]  opImm,
  output ctrlStrobe_t strobe,
  output logic        resValid
);

  copyMode_t copiesDec;

  always_comb begin
    unique case (opImm[2:1])
      2'b01:   copiesDec = CP_TWO;
      2'b10:   copiesDec = CP_FOUR;
      default: copiesDec = CP_ONE;
    endcase
  end

  always_comb begin
    strobe.load      = opValid;
    strobe.isCheck   = opCheck;
    strobe.complMode = opImm[0];
    strobe.copies    = copiesDec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= opValid;
  end

  // R2: result appears exactly one cycle after an accepted operation
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);

endmodule

// File: rtl/redun_gen.sv
module redun_gen
  import redun_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] srcWord,
  input  logic              complMode,
  input  copyMode_t         copies,
  output logic [WORD_W-1:0] genWord
);

  localparam int HALF_W  = WORD_W / 2;
  localparam int QUART_W = WORD_W / 4;

  logic [WORD_W-1:0] twoWord;
  logic [WORD_W-1:0] fourWord;

  for (genvar k = 0; k < 2; k++) begin : g_half
    localparam bit INV = (k % 2 == 1);
    assign twoWord[k*HALF_W +: HALF_W] =
      srcWord[HALF_W-1:0] ^ {HALF_W{complMode & INV}};
  end

  for (genvar k = 0; k < 4; k++) begin : g_quart
    localparam bit INV = (k % 2 == 1);
    assign fourWord[k*QUART_W +: QUART_W] =
      srcWord[QUART_W-1:0] ^ {QUART_W{complMode & INV}};
  end

  always_comb begin
    unique case (copies)
      CP_TWO:  genWord = twoWord;
      CP_FOUR: genWord = fourWord;
      default: genWord = srcWord;
    endcase
  end

endmodule

// File: rtl/redun_chk.sv
module redun_chk
  import redun_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] chkIn,
  input  logic              complMode,
  input  copyMode_t         copies,
  output logic [WORD_W-1:0] chkWord,
  output logic              chkFault
);

  localparam int HALF_W  = WORD_W / 2;
  localparam int QUART_W = WORD_W / 4;

  // two-copy disagreement: xnor for inverted pairs, xor for exact pairs
  logic [HALF_W-1:0] pairDiff;
  assign pairDiff = chkIn[WORD_W-1:HALF_W] ^ chkIn[HALF_W-1:0] ^ {HALF_W{complMode}};

  // four-copy path: undo inversion on odd copies, then vote
  logic [QUART_W-1:0] nrm [4];

  for (genvar k = 0; k < 4; k++) begin : g_nrm
    localparam bit INV = (k % 2 == 1);
    assign nrm[k] = chkIn[k*QUART_W +: QUART_W] ^ {QUART_W{complMode & INV}};
  end

  logic [QUART_W-1:0] vote;
  logic [QUART_W-1:0] spread;

  // ties fall back on copy 0
  assign vote   = (nrm[0] & (nrm[1] | nrm[2] | nrm[3])) | (nrm[1] & nrm[2] & nrm[3]);
  assign spread = (nrm[0] ^ nrm[1]) | (nrm[0] ^ nrm[2]) | (nrm[0] ^ nrm[3]);

  always_comb begin
    chkWord  = '0;
    chkFault = 1'b0;
    unique case (copies)
      CP_TWO: begin
        chkWord[HALF_W-1:0] = pairDiff;
        chkFault            = |pairDiff;
      end
      CP_FOUR: begin
        chkWord[QUART_W-1:0] = vote;
        chkFault             = |spread;
      end
      default: begin
        chkWord = chkIn;
      end
    endcase
  end

endmodule

// File: rtl/redun_dp.sv
module redun_dp
  import redun_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] opData,
  output logic [WORD_W-1:0] resData,
  output logic              resFault
);

  localparam int HALF_W  = WORD_W / 2;
  localparam int QUART_W = WORD_W / 4;

  logic [WORD_W-1:0] genWord;
  logic [WORD_W-1:0] chkWord;
  logic              chkFault;

  redun_gen #(.WORD_W(WORD_W)) u_gen (
    .srcWord   (opData),
    .complMode (strobe.complMode),
    .copies    (strobe.copies),
    .genWord   (genWord)
  );

  redun_chk #(.WORD_W(WORD_W)) u_chk (
    .chkIn     (opData),
    .complMode (strobe.complMode),
    .copies    (strobe.copies),
    .chkWord   (chkWord),
    .chkFault  (chkFault)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resFault <= 1'b0;
    end else if (strobe.load) begin
      resData  <= strobe.isCheck ? chkWord : genWord;
      resFault <= strobe.isCheck & chkFault;
    end
  end

  // R2: outputs hold while no operation is presented
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(resData) && $stable(resFault)));

  // R10: generation never flags a fault
  p_gen_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.isCheck) |=> !resFault);

  // R3: single-copy mode is a pass-through without fault
  p_single_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.copies == CP_ONE) |=> (resData == $past(opData) && !resFault));

  // R6/R7: two-copy check clears the upper half and flags any nonzero difference
  p_two_check_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.isCheck && strobe.copies == CP_TWO) |=>
      (resData[WORD_W-1:HALF_W] == '0 && resFault == (resData != '0)));

  // R8: four-copy check result lives in the lowest quarter only
  p_four_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.isCheck && strobe.copies == CP_FOUR) |=>
      (resData[WORD_W-1:QUART_W] == '0));

endmodule

// File: rtl/redun_unit.sv
module redun_unit
  import redun_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opCheck,
  input  logic [2:0]        opImm,
  input  logic [WORD_W-1:0] opData,
  output logic              resValid,
  output logic [WORD_W-1:0] resData,
  output logic              resFault
);

  ctrlStrobe_t strobe;

  redun_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCheck  (opCheck),
    .opImm    (opImm),
    .strobe   (strobe),
    .resValid (resValid)
  );

  redun_dp #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opData   (opData),
    .resData  (resData),
    .resFault (resFault)
  );

  initial begin
    p_width_r3: assert (WORD_W % 4 == 0 && WORD_W >= 8);
  end

endmodule

// File: tb/redun_unit_test.sv
`timescale 1ns/1ps
module redun_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opCheck = 1'b0;
  logic [2:0]  opImm = 3'b000;
  logic [31:0] opData = '0;
  logic        resValid;
  logic [31:0] resData;
  logic        resFault;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [31:0] lastData;
  logic        lastFault;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  redun_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCheck(opCheck),
    .opImm(opImm), .opData(opData),
    .resValid(resValid), .resData(resData), .resFault(resFault)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // reference model: {fault, word}, computed bit by bit from the requirements
  function automatic logic [32:0] model(input logic chk, input logic [2:0] imm,
                                        input logic [31:0] x);
    int rs, seg, cnt;
    logic [31:0] y;
    logic f;
    logic [3:0] v;
    rs  = (imm[2:1] == 2'b01) ? 2 : (imm[2:1] == 2'b10) ? 4 : 1;
    seg = 32 / rs;
    y = '0;
    f = 1'b0;
    if (!chk) begin
      for (int i = 0; i < 32; i++)
        y[i] = x[i % seg] ^ (imm[0] && ((i / seg) % 2 == 1));
    end else if (rs == 1) begin
      y = x;
    end else if (rs == 2) begin
      for (int j = 0; j < 16; j++)
        y[j] = imm[0] ? (x[j] == x[j+16]) : (x[j] != x[j+16]);
      f = (y != 0);
    end else begin
      for (int j = 0; j < 8; j++) begin
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
          v[k] = x[j + 8*k] ^ (imm[0] && (k % 2 == 1));
          cnt += int'(v[k]);
          if (v[k] != v[0]) f = 1'b1;
        end
        y[j] = (cnt > 2) ? 1'b1 : (cnt < 2) ? 1'b0 : v[0];
      end
    end
    return {f, y};
  endfunction

  task automatic runOp(input logic chk, input logic [2:0] imm,
                       input logic [31:0] x, input string tag);
    logic [32:0] e;
    @(negedge clk);
    opValid = 1'b1; opCheck = chk; opImm = imm; opData = x;
    @(negedge clk);
    opValid = 1'b0; opData = ~x; opCheck = ~chk;
    e = model(chk, imm, x);
    vectors++;
    if (resValid !== 1'b1 || resData !== e[31:0] || resFault !== e[32]) begin
      miscompares++;
      $display("FAIL %s chk=%0b imm=%03b in=%08h: got v=%0b d=%08h f=%0b exp v=1 d=%08h f=%0b",
               tag, chk, imm, x, resValid, resData, resFault, e[31:0], e[32]);
    end
    lastData  = e[31:0];
    lastFault = e[32];
  endtask

  task automatic checkIdle(input string tag);
    @(negedge clk);
    opData = nextRand(opData);
    opImm  = opImm + 3'd1;
    vectors++;
    if (resValid !== 1'b0 || resData !== lastData || resFault !== lastFault) begin
      miscompares++;
      $display("FAIL %s idle: got v=%0b d=%08h f=%0b exp v=0 d=%08h f=%0b",
               tag, resValid, resData, resFault, lastData, lastFault);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R1: reset values
    vectors++;
    if (resValid !== 1'b0 || resData !== '0 || resFault !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: got v=%0b d=%08h f=%0b exp 0 0 0", resValid, resData, resFault);
    end
    rstN = 1'b1;
    @(negedge clk);
    vectors++;
    if (resValid !== 1'b0 || resData !== '0 || resFault !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 post-reset: got v=%0b d=%08h f=%0b exp 0 0 0", resValid, resData, resFault);
    end

    // generate sweep over all immediates (R3, R4, R5)
    for (int imm = 0; imm < 8; imm++) begin
      for (int p = 0; p < 40; p++) begin
        if (p == 0) w = 32'h0;
        else if (p == 1) w = 32'hFFFF_FFFF;
        else if (p == 2) w = 32'hA5C3_0F69;
        else begin rng = nextRand(rng); w = rng; end
        if (imm[2:1] == 2'b01)      runOp(1'b0, 3'(imm), w, "R4");
        else if (imm[2:1] == 2'b10) runOp(1'b0, 3'(imm), w, "R5");
        else                        runOp(1'b0, 3'(imm), w, "R3");
      end
      checkIdle("R2");
    end

    // R10: same operand, operation selected by opCheck
    for (int p = 0; p < 16; p++) begin
      rng = nextRand(rng);
      runOp(1'b0, 3'b101, rng, "R10");
      runOp(1'b1, 3'b101, rng, "R10");
    end

    // single-copy checks (R3)
    for (int imm = 0; imm < 8; imm++) begin
      if (imm[2:1] == 2'b00 || imm[2:1] == 2'b11) begin
        for (int p = 0; p < 12; p++) begin
          rng = nextRand(rng);
          runOp(1'b1, 3'(imm), rng, "R3");
        end
      end
    end

    // two-copy checks: clean, single flips, random (R6 inverted, R7 exact)
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 24; p++) begin
        logic [32:0] g;
        rng = nextRand(rng);
        g = model(1'b0, {2'b01, 1'(c)}, rng);
        runOp(1'b1, {2'b01, 1'(c)}, g[31:0], c ? "R6" : "R7");
        for (int b = 0; b < 32; b += 5)
          runOp(1'b1, {2'b01, 1'(c)}, g[31:0] ^ (32'h1 << b), c ? "R6" : "R7");
        runOp(1'b1, {2'b01, 1'(c)}, rng, c ? "R6" : "R7");
      end
      checkIdle("R2");
    end

    // four-copy checks, every slice value (R8 vote and tie, R9 fault)
    for (int c = 0; c < 2; c++) begin
      for (int base = 0; base < 256; base++) begin
        logic [32:0] g;
        g = model(1'b0, {2'b10, 1'(c)}, {24'h0, 8'(base)});
        runOp(1'b1, {2'b10, 1'(c)}, g[31:0], "R8");
        for (int b = 0; b < 32; b++)
          runOp(1'b1, {2'b10, 1'(c)}, g[31:0] ^ (32'h1 << b), "R9");
        // 2-2 tie in bit j: copies 2 and 3 disagree with copies 0 and 1
        runOp(1'b1, {2'b10, 1'(c)},
              g[31:0] ^ (32'h1 << (16 + base % 8)) ^ (32'h1 << (24 + base % 8)), "R8");
      end
      checkIdle("R2");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule